// File: doc/BRIEF.md
# UART Interrupt Source Priority Encoder

This block gathers every interrupt condition of one serial-port channel and presents the most urgent one as a 3-bit status code, together with an interrupt request line. Event inputs are one-cycle pulses or levels from logic outside the block: the receive FIFO fill comparator, the four receive error bits, the receive idle time-out, the transmitter empty events, modem-control deltas, flow-control character detection and the general-purpose timer expiry. Register-read strobes from the host bus, along with the receive FIFO empty level, retire the sources.

Each event source sets a sticky pending flag, and each flag has its own clear event. Software reads the status code, services the named source, and the next pending source appears on its own. A per-group enable vector masks sources before encoding. Masking does not discard pending state. The timer source exists only when the channel index parameter is zero.

Top module: `uart_irq_prio`

## Requirements
- R1: After a synchronous reset, `isr_code` is 000 and `irq` is low.
- R2: The code values are 001 (receive data or line error), 010 (receive time-out), 011 (transmit empty), 100 (modem delta or flow character) and 111 (timer). When several sources are pending, the lowest non-zero value wins. A pulse or level change shows on the outputs at the second rising edge after it is sampled, and is not visible after the first.
- R3: The receive-data part of code 001 follows the `rx_above_trig` level, with no read strobe needed. Once the level falls, that part is gone.
- R4: Any set bit of `lsr_err` latches the line-error part of code 001. It stays pending until a `rd_lsr` strobe.
- R5: The receive time-out stays pending until `rx_fifo_empty` is high. Strobes on `rd_lsr`, `rd_isr` and `rd_msr` leave it pending.
- R6: The transmit source is set by `thr_empty` when `rs485_mode` is 0, and by `tsr_empty` when `rs485_mode` is 1. The other event is ignored. It is cleared by `rd_isr` only if the code presented during that strobe is 011.
- R7: A modem delta (`msr_delta`) clears only on `rd_msr`. A flow/special character detection (`flow_char_det`) clears only on `rd_isr` while the presented code is 100.
- R8: The timer source clears on `rd_tmr_ctl`. With `CHANNEL_ID` not equal to 0, code 111 never appears.
- R9: The enable bits are: bit 0 for receive data and time-out, bit 1 for line errors, bit 2 for transmit, bit 3 for modem/flow, and bit 4 for the timer. A low enable hides its sources, but their pending state is kept. Raising the enable shows the source one rising edge later.
- R10: Codes 101 and 110 are never produced.
- R11: `irq` is high exactly when `isr_code` is non-zero.
- R12: When a set event and a clear event reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 5 | Per-group interrupt enables (see R9) |
| rx_above_trig | input | 1 | Receive FIFO level at or above trigger |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| lsr_err | input | 4 | Receive error bits, pulse |
| rx_timeout | input | 1 | Receive idle time-out pulse |
| thr_empty | input | 1 | Holding register became empty, pulse |
| tsr_empty | input | 1 | Shift register became empty, pulse |
| rs485_mode | input | 1 | Selects shift-register empty as transmit source |
| msr_delta | input | 1 | Modem control line change, pulse |
| flow_char_det | input | 1 | Xon/Xoff or special character seen, pulse |
| timer_expired | input | 1 | Timer time-out pulse |
| rd_isr | input | 1 | Status register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| rd_tmr_ctl | input | 1 | Timer control register read strobe |
| isr_code | output | 3 | Highest-priority pending code |
| irq | output | 1 | Interrupt request |

## Verification
Every event and clear path passes through a pending register and then the output register. Its effect is therefore due at the second rising edge, while a change of the enable vector is due at the first. The bench drives inputs at falling edges and drops all strobes one falling edge later. It then samples at the next falling edge, which falls just after the second rising edge. One check per sequence samples after only one edge to confirm the result is not early. The enable sweep samples one falling edge after each change.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    CODE_NONE = 3'd0,
    CODE_RX   = 3'd1,
    CODE_TMO  = 3'd2,
    CODE_TX   = 3'd3,
    CODE_MDM  = 3'd4,
    CODE_TMR  = 3'd7
  } isr_code_e;

  // enable vector bit positions
  localparam int EN_RX   = 0;
  localparam int EN_LINE = 1;
  localparam int EN_TX   = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_TMR  = 4;
  localparam int EN_W    = 5;

  // sticky flag indices
  localparam int S_LINE = 0;
  localparam int S_TMO  = 1;
  localparam int S_TX   = 2;
  localparam int S_MDM  = 3;
  localparam int S_FLOW = 4;
  localparam int S_TMR  = 5;
  localparam int NSRC   = 6;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        pend_o[i] <= 1'b0;
      else if (set_i[i])
        pend_o[i] <= 1'b1;   // set wins over clear
      else if (clr_i[i])
        pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_encoder.sv
module uart_irq_encoder
  import uart_irq_pkg::*;
(
  input  logic [EN_W-1:0] en_i,
  input  logic            rx_lvl_i,
  input  logic [NSRC-1:0] pend_i,
  output isr_code_e       code_o
);
  logic lvl_rx, lvl_tmo, lvl_tx, lvl_mdm, lvl_tmr;

  always_comb begin
    lvl_rx  = (en_i[EN_RX] & rx_lvl_i) | (en_i[EN_LINE] & pend_i[S_LINE]);
    lvl_tmo = en_i[EN_RX] & pend_i[S_TMO];
    lvl_tx  = en_i[EN_TX] & pend_i[S_TX];
    lvl_mdm = en_i[EN_MDM] & (pend_i[S_MDM] | pend_i[S_FLOW]);
    lvl_tmr = en_i[EN_TMR] & pend_i[S_TMR];
    if (lvl_rx)       code_o = CODE_RX;
    else if (lvl_tmo) code_o = CODE_TMO;
    else if (lvl_tx)  code_o = CODE_TX;
    else if (lvl_mdm) code_o = CODE_MDM;
    else if (lvl_tmr) code_o = CODE_TMR;
    else              code_o = CODE_NONE;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL_ID = 0,
  parameter int ERR_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EN_W-1:0]  irq_en,
  input  logic             rx_above_trig,
  input  logic             rx_fifo_empty,
  input  logic [ERR_W-1:0] lsr_err,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             tsr_empty,
  input  logic             rs485_mode,
  input  logic             msr_delta,
  input  logic             flow_char_det,
  input  logic             timer_expired,
  input  logic             rd_isr,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             rd_tmr_ctl,
  output logic [2:0]       isr_code,
  output logic             irq
);
  localparam bit HAS_TIMER = (CHANNEL_ID == 0);

  logic [NSRC-1:0] set_v, clr_v, pend;
  logic            rx_lvl_q;
  logic            tmr_set;
  isr_code_e       code_d;
  logic            isr_rd_tx, isr_rd_mdm;

  generate
    if (HAS_TIMER) begin : g_tmr
      assign tmr_set = timer_expired;
    end else begin : g_no_tmr
      assign tmr_set = 1'b0;
    end
  endgenerate

  // status reads retire only the source that was being presented
  assign isr_rd_tx  = rd_isr && (isr_code == CODE_TX);
  assign isr_rd_mdm = rd_isr && (isr_code == CODE_MDM);

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[S_LINE] = |lsr_err;
    clr_v[S_LINE] = rd_lsr;
    set_v[S_TMO]  = rx_timeout;
    clr_v[S_TMO]  = rx_fifo_empty;
    set_v[S_TX]   = rs485_mode ? tsr_empty : thr_empty;
    clr_v[S_TX]   = isr_rd_tx;
    set_v[S_MDM]  = msr_delta;
    clr_v[S_MDM]  = rd_msr;
    set_v[S_FLOW] = flow_char_det;
    clr_v[S_FLOW] = isr_rd_mdm;
    set_v[S_TMR]  = tmr_set;
    clr_v[S_TMR]  = rd_tmr_ctl;
  end

  uart_irq_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .pend_o (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_lvl_q <= 1'b0;
    else     rx_lvl_q <= rx_above_trig;
  end

  uart_irq_encoder u_enc (
    .en_i     (irq_en),
    .rx_lvl_i (rx_lvl_q),
    .pend_i   (pend),
    .code_o   (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_code <= CODE_NONE;
      irq      <= 1'b0;
    end else begin
      isr_code <= code_d;
      irq      <= (code_d != CODE_NONE);
    end
  end
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter int CHANNEL_ID = 0
) (
  input logic       clk,
  input logic       rst,
  input logic [4:0] irq_en,
  input logic [2:0] isr_code,
  input logic       irq
);
  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (isr_code != 3'd5) && (isr_code != 3'd6));

  assert_irq_code_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (isr_code != 3'd0));

  assert_timer_chan_R8: assert property (@(posedge clk) disable iff (rst)
    (CHANNEL_ID != 0) |-> (isr_code != 3'd7));

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr_code == 3'd0) && !irq);

  assert_mask_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(irq_en) != 5'd0));
endmodule

bind uart_irq_prio uart_irq_prio_chk #(.CHANNEL_ID(CHANNEL_ID)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_en   (irq_en),
  .isr_code (isr_code),
  .irq      (irq)
);

// File: tb/uart_irq_prio_tb.sv
`timescale 1ns/1ps
module uart_irq_prio_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] irq_en = 5'h1F;
  logic       rx_above_trig = 0, rx_fifo_empty = 0;
  logic [3:0] lsr_err = 0;
  logic       rx_timeout = 0, thr_empty = 0, tsr_empty = 0, rs485_mode = 0;
  logic       msr_delta = 0, flow_char_det = 0, timer_expired = 0;
  logic       rd_isr = 0, rd_lsr = 0, rd_msr = 0, rd_tmr_ctl = 0;
  logic [2:0] code0, code1;
  logic       irq0, irq1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_prio #(.CHANNEL_ID(0)) u_dut (
    .clk(clk), .rst(rst), .irq_en(irq_en), .rx_above_trig(rx_above_trig),
    .rx_fifo_empty(rx_fifo_empty), .lsr_err(lsr_err), .rx_timeout(rx_timeout),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rs485_mode(rs485_mode),
    .msr_delta(msr_delta), .flow_char_det(flow_char_det),
    .timer_expired(timer_expired), .rd_isr(rd_isr), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .rd_tmr_ctl(rd_tmr_ctl), .isr_code(code0), .irq(irq0));

  uart_irq_prio #(.CHANNEL_ID(1)) u_dut1 (
    .clk(clk), .rst(rst), .irq_en(irq_en), .rx_above_trig(rx_above_trig),
    .rx_fifo_empty(rx_fifo_empty), .lsr_err(lsr_err), .rx_timeout(rx_timeout),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rs485_mode(rs485_mode),
    .msr_delta(msr_delta), .flow_char_det(flow_char_det),
    .timer_expired(timer_expired), .rd_isr(rd_isr), .rd_lsr(rd_lsr),
    .rd_msr(rd_msr), .rd_tmr_ctl(rd_tmr_ctl), .isr_code(code1), .irq(irq1));

  function automatic logic [2:0] model(input logic [4:0] e, input logic rx,
      input logic ln, input logic to, input logic tx, input logic md, input logic tm);
    if ((e[0] & rx) | (e[1] & ln)) return 3'd1;
    if (e[0] & to)                 return 3'd2;
    if (e[2] & tx)                 return 3'd3;
    if (e[3] & md)                 return 3'd4;
    if (e[4] & tm)                 return 3'd7;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic act_irq,
                     input logic [2:0] exp);
    checks++;
    if (act !== exp || act_irq !== (exp != 3'd0) || act == 3'd5 || act == 3'd6) begin
      errors++;
      $display("FAIL %s: code=%0d irq=%0b expected code=%0d irq=%0b",
               req, act, act_irq, exp, (exp != 3'd0));
    end
  endtask

  // strobes last one cycle; result due after the second rising edge
  task automatic step2();
    @(negedge clk);
    lsr_err = 0; rx_timeout = 0; thr_empty = 0; tsr_empty = 0;
    msr_delta = 0; flow_char_det = 0; timer_expired = 0; rx_fifo_empty = 0;
    rd_isr = 0; rd_lsr = 0; rd_msr = 0; rd_tmr_ctl = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ch0", code0, irq0, 3'd0);
    chk("R1 reset ch1", code1, irq1, 3'd0);

    // R2 latency: one edge is too early, two edges is due
    rx_above_trig = 1;
    @(negedge clk);
    chk("R2 not early", code0, irq0, 3'd0);
    @(negedge clk);
    chk("R3 rx level shown", code0, irq0, 3'd1);
    rx_above_trig = 0;
    step2();
    chk("R3 rx level gone", code0, irq0, 3'd0);

    // every source pending, then sweep all enable patterns (R2, R9, R8, R11, R10)
    rx_above_trig = 1; lsr_err = 4'b0001; rx_timeout = 1; thr_empty = 1;
    msr_delta = 1; flow_char_det = 1; timer_expired = 1;
    step2();
    for (int e = 0; e < 32; e++) begin
      irq_en = e[4:0];
      @(negedge clk);
      chk("R9 R2 sweep ch0", code0, irq0, model(e[4:0], 1, 1, 1, 1, 1, 1));
      chk("R8 sweep ch1",    code1, irq1, model(e[4:0], 1, 1, 1, 1, 1, 0));
    end
    irq_en = 5'h1F;
    @(negedge clk);
    chk("R2 all pending", code0, irq0, 3'd1);

    rx_above_trig = 0; step2();
    chk("R3 line part remains", code0, irq0, 3'd1);
    rd_lsr = 1; step2();
    chk("R4 line cleared by lsr read", code0, irq0, 3'd2);
    rd_isr = 1; step2();
    chk("R6 isr read under 010 keeps tx", code0, irq0, 3'd2);
    rd_lsr = 1; rd_msr = 1; step2();
    chk("R5 reads keep time-out", code0, irq0, 3'd2);
    rx_fifo_empty = 1; step2();
    chk("R5 time-out cleared by empty", code0, irq0, 3'd3);
    rd_msr = 1; step2();
    chk("R7 msr read under 011", code0, irq0, 3'd3);
    rd_isr = 1; step2();
    chk("R6 tx cleared, R7 flow kept", code0, irq0, 3'd4);
    rd_isr = 1; step2();
    chk("R7 flow cleared by isr read", code0, irq0, 3'd7);
    chk("R8 no timer on ch1", code1, irq1, 3'd0);
    rd_tmr_ctl = 1; step2();
    chk("R8 timer cleared", code0, irq0, 3'd0);

    // R6 transmit source selection
    rs485_mode = 1; thr_empty = 1; step2();
    chk("R6 thr ignored in rs485", code0, irq0, 3'd0);
    tsr_empty = 1; step2();
    chk("R6 tsr sets in rs485", code0, irq0, 3'd3);
    rd_isr = 1; step2();
    chk("R6 tx cleared", code0, irq0, 3'd0);
    rs485_mode = 0; tsr_empty = 1; step2();
    chk("R6 tsr ignored normal mode", code0, irq0, 3'd0);

    // R12 set beats clear
    lsr_err = 4'b0100; rd_lsr = 1; step2();
    chk("R12 set wins", code0, irq0, 3'd1);
    rd_lsr = 1; step2();
    chk("R4 cleared after", code0, irq0, 3'd0);

    // R9 masked source kept pending
    irq_en = 5'h00; msr_delta = 1; step2();
    chk("R9 masked hidden", code0, irq0, 3'd0);
    irq_en = 5'h1F;
    @(negedge clk);
    chk("R9 unmasked shown", code0, irq0, 3'd4);
    rd_isr = 1; step2();
    chk("R7 isr read keeps modem delta", code0, irq0, 3'd4);
    rd_msr = 1; step2();
    chk("R7 modem cleared", code0, irq0, 3'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule